// File: doc/BRIEF.md
# Event and List Packet Transmitter

This block assembles one outgoing packet each time the surrounding device has an event to signal or a list of data words to hand back. A single start request supplies a target address of up to four bytes, a payload type byte, a payload length in 32-bit words and a count of fill bytes. The block then produces the packet one byte at a time on a valid/ready stream, ending with a separate end-of-packet beat.

The packet is built in this order:

- the significant bytes of the target address;
- the command byte of the list/event operation;
- the type byte;
- the payload words, each split most significant byte first;
- any zero fill bytes;
- a one-byte additive checksum.

Payload words are pulled one at a time through a request/acknowledge word interface, so the block never buffers more than one word. Leading zero bytes of the target address are not sent. This leaves a shorter route prefix for nearby destinations.

A done pulse tells the requester that the end-of-packet beat has been taken and that a new start may be issued.

Top module: `evpkt_tx`

## Requirements
- R1: After reset `busy_o`, `done_o`, `tx_valid_o` and `wreq_o` are all low.
- R2: The address bytes sent are bytes k down to 0 of `target_i`, where byte i is bits 8i+7..8i and k is the highest byte index holding a non-zero value. Zero bytes below byte k are still sent.
- R3: When `target_i` is all zero, exactly one address byte of value 0x00 is sent.
- R4: The byte after the address is the command byte 0x92 with the fill count placed in bits 6:5, so it is 0x92 when no fill is requested.
- R5: The type byte follows the command byte. Then come `nwords_i` payload words, each taken through one `wreq_o`/`wack_i` handshake and sent most significant byte first. A length of zero causes no word request.
- R6: `nfill_i` bytes of value 0x00 (0 to 3) follow the payload and precede the checksum.
- R7: The checksum byte is the modulo-256 sum of the command, type, payload and fill bytes, with the address bytes excluded. It is followed by one beat with `tx_eop_o` high and `tx_data_o` equal to 0x00.
- R8: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o` and `tx_eop_o` hold their values and `tx_valid_o` stays high.
- R9: `start_i` is accepted only while `busy_o` is low. A start raised during a packet changes neither that packet nor what follows it.
- R10: `done_o` is high for exactly one cycle, in the cycle after the end-of-packet beat is accepted, and `busy_o` is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to build a packet |
| target_i | input | 32 | Target address, byte 3 most significant |
| ptype_i | input | 8 | Payload type byte |
| nwords_i | input | 8 | Payload length in 32-bit words |
| nfill_i | input | 2 | Number of fill bytes |
| busy_o | output | 1 | A packet is in progress |
| done_o | output | 1 | One-cycle pulse after end-of-packet |
| wreq_o | output | 1 | Request for the next payload word |
| wack_i | input | 1 | The word on `wdata_i` is taken this cycle |
| wdata_i | input | 32 | Payload word |
| tx_valid_o | output | 1 | A byte or end-of-packet beat is offered |
| tx_ready_i | input | 1 | Downstream accepts the offered beat |
| tx_data_o | output | 8 | Packet byte |
| tx_eop_o | output | 1 | The offered beat is end-of-packet |

## Verification
The embedded assertions watch, every cycle, that a stalled beat stays frozen, that the end-of-packet beat carries a zero byte, that word requests never overlap an offered beat, that the first address byte kept after trimming is non-zero, and that each done pulse follows an accepted end-of-packet beat. The bench alone can show the packet contents:

- the address trimming for several address shapes;
- the command byte with fill encoded;
- payload byte order;
- the number of word fetches;
- fill placement;
- checksum wrap-around over a maximum-length payload;
- that a start raised mid-packet is ignored.

// File: rtl/evpkt_pkg.sv
package evpkt_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CMD,
      ST_TYPE,
      ST_FETCH,
      ST_PAY,
      ST_FILL,
      ST_SUM,
      ST_EOP
   } evpkt_state_e;

   // list/event operation code, fill field cleared
   localparam logic [7:0] CMD_LIST_EVENT = 8'h92;
   // lowest bit of the fill count field in the command byte
   localparam int unsigned CMD_FILL_LSB = 5;
   localparam int unsigned CMD_FILL_BITS = 2;

endpackage

// File: rtl/evpkt_lead_trim.sv
module evpkt_lead_trim #(
   parameter int unsigned ADDR_BYTES = 4,
   parameter int unsigned IDX_W      = 2
) (
   input  logic [8*ADDR_BYTES-1:0] addr_i,
   output logic [IDX_W-1:0]        first_idx_o
);

   logic [ADDR_BYTES-1:0] nz;

   genvar g;
   generate
      for (g = 0; g < ADDR_BYTES; g++) begin : g_nz
         assign nz[g] = |addr_i[8*g +: 8];
      end
   endgenerate

   // highest non-zero byte wins; all-zero address selects byte 0
   always_comb begin
      first_idx_o = '0;
      for (int i = 0; i < ADDR_BYTES; i++) begin
         if (nz[i]) first_idx_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/evpkt_sum.sv
module evpkt_sum #(
   parameter int unsigned SUM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             add_i,
   input  logic [SUM_W-1:0] val_i,
   output logic [SUM_W-1:0] sum_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sum_o <= '0;
      else if (clr_i) sum_o <= '0;
      else if (add_i) sum_o <= sum_o + val_i;
   end

endmodule

// File: rtl/evpkt_word_lanes.sv
module evpkt_word_lanes #(
   parameter int unsigned WORD_BYTES = 4,
   parameter int unsigned SEL_W      = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_i,
   input  logic [8*WORD_BYTES-1:0] word_i,
   input  logic [SEL_W-1:0]        sel_i,
   output logic [7:0]              byte_o
);

   logic [8*WORD_BYTES-1:0] word_q;
   logic [7:0]              lane [WORD_BYTES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word_q <= '0;
      else if (load_i) word_q <= word_i;
   end

   genvar g;
   generate
      for (g = 0; g < WORD_BYTES; g++) begin : g_lane
         assign lane[g] = word_q[8*g +: 8];
      end
   endgenerate

   always_comb begin
      byte_o = '0;
      for (int i = 0; i < WORD_BYTES; i++) begin
         if (sel_i == SEL_W'(i)) byte_o = lane[i];
      end
   end

endmodule

// File: rtl/evpkt_tx.sv
module evpkt_tx
   import evpkt_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 4,
   parameter int unsigned WORD_BYTES = 4,
   parameter int unsigned LEN_W      = 8,
   parameter int unsigned FILL_W     = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [8*ADDR_BYTES-1:0] target_i,
   input  logic [7:0]              ptype_i,
   input  logic [LEN_W-1:0]        nwords_i,
   input  logic [FILL_W-1:0]       nfill_i,
   output logic                    busy_o,
   output logic                    done_o,
   output logic                    wreq_o,
   input  logic                    wack_i,
   input  logic [8*WORD_BYTES-1:0] wdata_i,
   output logic                    tx_valid_o,
   input  logic                    tx_ready_i,
   output logic [7:0]              tx_data_o,
   output logic                    tx_eop_o
);

   localparam int unsigned AIDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
   localparam int unsigned BIDX_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
   localparam logic [BIDX_W-1:0] LAST_LANE = BIDX_W'(WORD_BYTES - 1);

   generate
      if (ADDR_BYTES < 1 || ADDR_BYTES > 8) begin : g_bad_addr
         $error("evpkt_tx: ADDR_BYTES must be 1..8");
      end
      if (WORD_BYTES < 1 || WORD_BYTES > 8) begin : g_bad_word
         $error("evpkt_tx: WORD_BYTES must be 1..8");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("evpkt_tx: LEN_W must be 1..16");
      end
      if (FILL_W < 1 || FILL_W > CMD_FILL_BITS) begin : g_bad_fill
         $error("evpkt_tx: FILL_W must fit the command fill field");
      end
   endgenerate

   evpkt_state_e            state_q;
   logic [8*ADDR_BYTES-1:0] tgt_q;
   logic [7:0]              ptype_q;
   logic [LEN_W-1:0]        nwords_q;
   logic [FILL_W-1:0]       nfill_q;
   logic [FILL_W-1:0]       fcnt_q;
   logic [LEN_W-1:0]        wcnt_q;
   logic [AIDX_W-1:0]       aidx_q;
   logic [BIDX_W-1:0]       bidx_q;
   logic                    done_q;

   logic [AIDX_W-1:0]       first_idx;
   logic [7:0]              lane_byte;
   logic [7:0]              sum;
   logic [7:0]              cmd_byte;
   logic                    accept;
   logic                    fire;
   logic                    sum_add;
   logic                    load_word;

   evpkt_lead_trim #(
      .ADDR_BYTES (ADDR_BYTES),
      .IDX_W      (AIDX_W)
   ) u_trim (
      .addr_i      (target_i),
      .first_idx_o (first_idx)
   );

   evpkt_word_lanes #(
      .WORD_BYTES (WORD_BYTES),
      .SEL_W      (BIDX_W)
   ) u_lanes (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_word),
      .word_i (wdata_i),
      .sel_i  (bidx_q),
      .byte_o (lane_byte)
   );

   evpkt_sum #(
      .SUM_W (8)
   ) u_sum (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (accept),
      .add_i (sum_add),
      .val_i (tx_data_o),
      .sum_o (sum)
   );

   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = done_q;
   assign accept    = start_i && (state_q == ST_IDLE);
   assign wreq_o    = (state_q == ST_FETCH);
   assign load_word = wreq_o && wack_i;
   assign cmd_byte  = CMD_LIST_EVENT | (8'(nfill_q) << CMD_FILL_LSB);
   assign fire      = tx_valid_o && tx_ready_i;
   assign sum_add   = fire && (state_q == ST_CMD || state_q == ST_TYPE ||
                               state_q == ST_PAY || state_q == ST_FILL);

   always_comb begin
      tx_valid_o = 1'b1;
      tx_eop_o   = 1'b0;
      tx_data_o  = 8'h00;
      unique case (state_q)
         ST_ADDR: tx_data_o = tgt_q[8*aidx_q +: 8];
         ST_CMD:  tx_data_o = cmd_byte;
         ST_TYPE: tx_data_o = ptype_q;
         ST_PAY:  tx_data_o = lane_byte;
         ST_FILL: tx_data_o = 8'h00;
         ST_SUM:  tx_data_o = sum;
         ST_EOP:  tx_eop_o  = 1'b1;
         default: tx_valid_o = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         tgt_q    <= '0;
         ptype_q  <= '0;
         nwords_q <= '0;
         nfill_q  <= '0;
         fcnt_q   <= '0;
         wcnt_q   <= '0;
         aidx_q   <= '0;
         bidx_q   <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  tgt_q    <= target_i;
                  ptype_q  <= ptype_i;
                  nwords_q <= nwords_i;
                  nfill_q  <= nfill_i;
                  fcnt_q   <= nfill_i;
                  aidx_q   <= first_idx;
                  wcnt_q   <= '0;
                  state_q  <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               if (fire) begin
                  if (aidx_q == '0) state_q <= ST_CMD;
                  else              aidx_q  <= aidx_q - AIDX_W'(1);
               end
            end
            ST_CMD: begin
               if (fire) state_q <= ST_TYPE;
            end
            ST_TYPE: begin
               if (fire) begin
                  if (nwords_q != '0)     state_q <= ST_FETCH;
                  else if (fcnt_q != '0)  state_q <= ST_FILL;
                  else                    state_q <= ST_SUM;
               end
            end
            ST_FETCH: begin
               if (wack_i) begin
                  bidx_q  <= LAST_LANE;
                  state_q <= ST_PAY;
               end
            end
            ST_PAY: begin
               if (fire) begin
                  if (bidx_q != '0) begin
                     bidx_q <= bidx_q - BIDX_W'(1);
                  end else if (wcnt_q == nwords_q - LEN_W'(1)) begin
                     state_q <= (fcnt_q != '0) ? ST_FILL : ST_SUM;
                  end else begin
                     wcnt_q  <= wcnt_q + LEN_W'(1);
                     state_q <= ST_FETCH;
                  end
               end
            end
            ST_FILL: begin
               if (fire) begin
                  fcnt_q <= fcnt_q - FILL_W'(1);
                  if (fcnt_q == FILL_W'(1)) state_q <= ST_SUM;
               end
            end
            ST_SUM: begin
               if (fire) state_q <= ST_EOP;
            end
            ST_EOP: begin
               if (fire) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R8: a stalled beat is frozen until taken
   a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_eop_o)));

   // R10: done only right after an accepted end-of-packet beat
   a_r10_done_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(tx_valid_o && tx_ready_i && tx_eop_o)));

   // R7: end-of-packet beat carries a zero byte
   a_r7_eop_zero: assert property (@(posedge clk) disable iff (!rst_n)
      tx_eop_o |-> (tx_valid_o && tx_data_o == 8'h00));

   // R5: a word fetch never overlaps an offered beat
   a_r5_fetch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      wreq_o |-> !tx_valid_o);

   // R2: the first address byte kept after trimming is non-zero unless it is byte 0
   a_r2_first_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (aidx_q == '0 || tx_data_o != 8'h00));

endmodule

// File: tb/evpkt_tx_bench.sv
`timescale 1ns/1ps
module evpkt_tx_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i;
   logic [31:0] target_i;
   logic [7:0]  ptype_i;
   logic [7:0]  nwords_i;
   logic [1:0]  nfill_i;
   logic        busy_o, done_o, wreq_o;
   logic        wack_i;
   logic [31:0] wdata_i;
   logic        tx_valid_o, tx_ready_i, tx_eop_o;
   logic [7:0]  tx_data_o;

   always #4 clk = ~clk;

   evpkt_tx u_evpkt_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .target_i   (target_i),
      .ptype_i    (ptype_i),
      .nwords_i   (nwords_i),
      .nfill_i    (nfill_i),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .wreq_o     (wreq_o),
      .wack_i     (wack_i),
      .wdata_i    (wdata_i),
      .tx_valid_o (tx_valid_o),
      .tx_ready_i (tx_ready_i),
      .tx_data_o  (tx_data_o),
      .tx_eop_o   (tx_eop_o)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int fetches = 0;
   int rdy_mode = 0;
   int ack_mode = 0;
   logic [31:0] wmem [256];
   logic [8:0]  rx_q [$];
   logic        hold_pend = 1'b0;
   logic [8:0]  hold_val = '0;

   task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // collector and word counter
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && tx_valid_o && tx_ready_i) rx_q.push_back({tx_eop_o, tx_data_o});
      if (rst_n && wreq_o && wack_i) fetches <= fetches + 1;
   end

   // stall hold monitor (R8)
   always @(posedge clk) begin
      if (rst_n && hold_pend)
         check(tx_valid_o && ({tx_eop_o, tx_data_o} == hold_val), "R8 stalled beat held",
               {23'd0, tx_eop_o, tx_data_o}, {23'd0, hold_val});
      hold_pend <= rst_n && tx_valid_o && !tx_ready_i;
      hold_val  <= {tx_eop_o, tx_data_o};
   end

   // downstream ready and word supplier
   always @(negedge clk) begin
      tx_ready_i <= (rdy_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
      wack_i     <= wreq_o && ((ack_mode == 0) || ((cyc % 3) == 0));
      wdata_i    <= wmem[fetches[7:0]];
   end

   task automatic do_reset();
      rst_n = 1'b0; start_i = 1'b0; target_i = '0; ptype_i = '0; nwords_i = '0; nfill_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !done_o && !tx_valid_o && !wreq_o, "R1 reset outputs",
            {28'd0, busy_o, done_o, tx_valid_o, wreq_o}, 32'd0);
   endtask

   task automatic run_pkt(input logic [31:0] tgt, input logic [7:0] pt, input int nw,
                          input int fl, input int rmode, input int amode, input bit poke);
      logic [8:0] eq [$];
      string      tq [$];
      logic [7:0] s;
      int         top;
      int         n;
      for (int i = 0; i < 256; i++) wmem[i] = (32'h9E3779B9 * (i + 1)) ^ {24'd0, pt};
      top = 0;
      for (int b = 0; b < 4; b++) if (tgt[8*b +: 8] != 8'h00) top = b;
      for (int b = top; b >= 0; b--) begin
         eq.push_back({1'b0, tgt[8*b +: 8]});
         tq.push_back((tgt == 0) ? "R3 zero address byte" : "R2 address byte");
      end
      s = 8'h92 | 8'(fl << 5);
      eq.push_back({1'b0, s}); tq.push_back("R4 command byte");
      eq.push_back({1'b0, pt}); tq.push_back("R5 type byte");
      s = s + pt;
      for (int w = 0; w < nw; w++) begin
         for (int b = 3; b >= 0; b--) begin
            eq.push_back({1'b0, wmem[w][8*b +: 8]}); tq.push_back("R5 payload byte");
            s = s + wmem[w][8*b +: 8];
         end
      end
      for (int f = 0; f < fl; f++) begin
         eq.push_back(9'h000); tq.push_back("R6 fill byte");
      end
      eq.push_back({1'b0, s}); tq.push_back("R7 checksum");
      eq.push_back(9'h100); tq.push_back("R7 end of packet");

      rx_q.delete();
      fetches  = 0;
      rdy_mode = rmode;
      ack_mode = amode;
      @(negedge clk);
      start_i = 1'b1; target_i = tgt; ptype_i = pt; nwords_i = 8'(nw); nfill_i = 2'(fl);
      @(negedge clk);
      start_i = 1'b0; target_i = 32'hDEAD_BEEF; ptype_i = 8'h5A; nwords_i = 8'd7; nfill_i = 2'd3;
      if (poke) begin
         repeat (2) @(negedge clk);
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      n = 0;
      while (!done_o && n < 20000) begin
         @(negedge clk);
         n++;
      end
      check(n < 20000, "R10 done reached", n, 20000);
      check(!busy_o, "R10 idle with done", {31'd0, busy_o}, 0);
      @(negedge clk);
      check(!done_o, "R10 done one cycle", {31'd0, done_o}, 0);
      repeat (5) @(negedge clk);
      check(!busy_o && rx_q.size() == eq.size(), poke ? "R9 no extra packet" : "R7 beat count",
            rx_q.size(), eq.size());
      check(fetches == nw, "R5 word fetch count", fetches, nw);
      for (int i = 0; i < eq.size() && i < rx_q.size(); i++)
         check(rx_q[i] == eq[i], tq[i], {23'd0, rx_q[i]}, {23'd0, eq[i]});
   endtask

   initial begin
      do_reset();
      run_pkt(32'h1234_5678, 8'h21, 3, 0, 0, 0, 1'b0);   // full address, no fill
      run_pkt(32'h0000_00A5, 8'h07, 1, 2, 0, 1, 1'b0);   // one address byte, fill 2
      run_pkt(32'h0000_0000, 8'hC3, 0, 0, 1, 0, 1'b0);   // R3 zero address, no payload
      run_pkt(32'h00AB_0001, 8'h3C, 4, 3, 1, 1, 1'b0);   // inner zero kept, stalls
      run_pkt(32'h0000_0102, 8'h99, 2, 1, 0, 0, 1'b1);   // R9 start while busy
      run_pkt(32'h8000_0000, 8'hFF, 255, 1, 1, 1, 1'b0); // long payload, sum wraps
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule